// File: doc/BRIEF.md
# Descriptor Ring Pointer Controller

This block manages one direction, transmit or receive, of a DMA engine that walks a ring of descriptors kept in host memory. It holds the descriptor list base address and the channel's run request. It tracks whether the channel is stopped, running or suspended, and it keeps the address of the current descriptor. While the channel is running it requests a fetch of that descriptor. The bus master then answers with an acknowledge and tells the block whether the DMA owns the descriptor and whether it is the last one in the ring.

Software starts the channel by writing the operation-mode word. On a start, the channel uses a base address only when that address was written while the channel was stopped. Otherwise it resumes at the descriptor where it stopped. A suspended channel waits for a poll-demand write, and then fetches the same descriptor again. A one-cycle pulse marks each entry into suspend, so that an outer status register can set a sticky bit.

Top module: `dma_desc_ptr_ctrl`

## Requirements
- R1: A base write is stored only while the state is STOPPED and the start bit is clear. In any other case the write is ignored, and `base_rd` keeps its previous value.
- R2: The stored base address has its low log2(BUS_W/8) bits forced to zero: 3 bits for a 64-bit bus and 4 bits for a 128-bit bus.
- R3: When the channel starts after a base write that was accepted while it was stopped, its first fetch address is that new base.
- R4: When the channel starts with no base write since it stopped, its first fetch address is the pointer it held when it stopped.
- R5: An acknowledge with `desc_owned`=1 while running advances the pointer by DESC_BYTES. If `desc_last`=1 as well, the pointer returns to the base instead.
- R6: An acknowledge with `desc_owned`=0 while running moves the state to SUSPENDED. On a transmit instance (IS_TX=1), `tx_underflow` while running also moves the state to SUSPENDED. A receive instance ignores `tx_underflow`.
- R7: A poll-demand write sets `poll_pend`. A suspended channel that is still started then returns to RUNNING and fetches the same address. `poll_pend` clears when that fetch begins.
- R8: The start bit is bit 13 of `opmode_wdata` on a transmit instance and bit 1 on a receive instance. All other bits have no effect.
- R9: Clearing the start bit stops a suspended channel on the next cycle. A running channel keeps `fetch_req` high until the acknowledge arrives, then enters STOPPED with its pointer unchanged.
- R10: `suspend_evt` is high for exactly the first cycle in which `state` shows SUSPENDED after another state.
- R11: After reset, `state` is STOPPED, `fetch_addr` is 0, `base_rd` is 0, `poll_pend` is 0 and `fetch_req` is 0.
- R12: `fetch_req` is high exactly while the state is RUNNING. `fetch_addr` does not change while a request waits for its acknowledge. The state encoding is STOPPED=0, RUNNING=1, SUSPENDED=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opmode_wr | input | 1 | Write strobe for the operation-mode word |
| opmode_wdata | input | OPM_W | Operation-mode word; only the start bit is used |
| base_wr | input | 1 | Write strobe for the descriptor list base |
| base_wdata | input | ADDR_W | New base address |
| poll_wr | input | 1 | Poll-demand command strobe |
| tx_underflow | input | 1 | Transmit underflow event (used only when IS_TX=1) |
| fetch_ack | input | 1 | Fetch of the current descriptor completed |
| desc_owned | input | 1 | Fetched descriptor is owned by the DMA (valid with ack) |
| desc_last | input | 1 | Fetched descriptor ends the ring (valid with ack) |
| fetch_req | output | 1 | Request to fetch the descriptor at fetch_addr |
| fetch_addr | output | ADDR_W | Current descriptor pointer |
| base_rd | output | ADDR_W | Stored, aligned base address |
| state | output | 2 | Channel state: 0 stopped, 1 running, 2 suspended |
| suspend_evt | output | 1 | One-cycle pulse on entering suspend |
| poll_pend | output | 1 | Poll demand is pending |

## Verification
The assertions check the following on every cycle:
- the stored base is aligned and stays unchanged while the channel is locked;
- the fetch address holds until an acknowledge arrives;
- the channel enters suspend only for an unowned descriptor, or for an underflow on transmit;
- a suspended channel with a pending poll wakes on the same pointer;
- the start-time choice between the new base and the old pointer is made correctly;
- the suspend pulse lines up with the state change.

Only the bench's scenarios can show the end-to-end sequences. These are: a ring walked through its wrap, a stop that has to wait for an outstanding acknowledge, a resume versus a restart across several stop/start rounds, and the bit-position selection of the start control on two differently configured instances.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
    typedef enum logic [1:0] {
        CH_STOPPED   = 2'd0,
        CH_RUNNING   = 2'd1,
        CH_SUSPENDED = 2'd2
    } ch_state_e;
endpackage

// File: rtl/dpc_base_reg.sv
module dpc_base_reg #(
    parameter int ADDR_W    = 32,
    parameter int ALIGN_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] wdata_i,
    input  logic              open_i,
    input  logic              take_i,
    output logic [ADDR_W-1:0] base_o,
    output logic              dirty_o
);
    localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << ALIGN_LSB) - ADDR_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic              dirty;
    } breg_t;

    breg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take_i) begin
            st_d.dirty = 1'b0;
        end
        if (wr_i && open_i) begin
            st_d.base  = wdata_i & ~LOW_MASK;
            st_d.dirty = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign base_o  = st_q.base;
    assign dirty_o = st_q.dirty;

    // R2
    base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.base & LOW_MASK) == '0);

    // R1
    base_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !open_i |=> $stable(st_q.base));
endmodule

// File: rtl/dpc_poll_flag.sv
module dpc_poll_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic poll_wr_i,
    input  logic fetch_start_i,
    output logic pend_o
);
    typedef struct packed {
        logic pend;
    } poll_t;

    poll_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fetch_start_i) begin
            st_d.pend = 1'b0;
        end
        if (poll_wr_i) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

    // R7
    poll_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_wr_i |=> st_q.pend);

    // R7
    poll_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_start_i && !poll_wr_i) |=> !st_q.pend);
endmodule

// File: rtl/dpc_chan_fsm.sv
module dpc_chan_fsm
    import dpc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DESC_BYTES = 16,
    parameter bit IS_TX      = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              opmode_wr_i,
    input  logic              start_bit_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              dirty_i,
    input  logic              poll_pend_i,
    input  logic              underflow_i,
    input  logic              fetch_ack_i,
    input  logic              desc_owned_i,
    input  logic              desc_last_i,
    output ch_state_e         state_o,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              take_o,
    output logic              open_o,
    output logic              fetch_start_o,
    output logic              suspend_evt_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

    typedef struct packed {
        ch_state_e         state;
        logic [ADDR_W-1:0] ptr;
        logic              run;
        logic              evt;
    } fsm_t;

    fsm_t st_d, st_q;
    logic uf_eff;

    generate
        if (IS_TX) begin : g_tx_uf
            assign uf_eff = underflow_i;
        end else begin : g_rx_uf
            assign uf_eff = 1'b0;
        end
    endgenerate

    always_comb begin
        st_d   = st_q;
        take_o = 1'b0;
        if (opmode_wr_i) begin
            st_d.run = start_bit_i;
        end
        unique case (st_q.state)
            CH_STOPPED: begin
                if (st_q.run) begin
                    st_d.state = CH_RUNNING;
                    if (dirty_i) begin
                        st_d.ptr = base_i;
                        take_o   = 1'b1;
                    end
                end
            end
            CH_RUNNING: begin
                if (uf_eff) begin
                    st_d.state = CH_SUSPENDED;
                end else if (fetch_ack_i) begin
                    if (!st_q.run) begin
                        st_d.state = CH_STOPPED;
                    end else if (desc_owned_i) begin
                        st_d.ptr = desc_last_i ? base_i : st_q.ptr + STEP;
                    end else begin
                        st_d.state = CH_SUSPENDED;
                    end
                end
            end
            CH_SUSPENDED: begin
                if (!st_q.run) begin
                    st_d.state = CH_STOPPED;
                end else if (poll_pend_i) begin
                    st_d.state = CH_RUNNING;
                end
            end
            default: st_d.state = CH_STOPPED;
        endcase
        st_d.evt = (st_d.state == CH_SUSPENDED) && (st_q.state != CH_SUSPENDED);
        fetch_start_o = (st_d.state == CH_RUNNING) &&
                        ((st_q.state != CH_RUNNING) || fetch_ack_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: CH_STOPPED, ptr: '0, run: 1'b0, evt: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o       = st_q.state;
    assign ptr_o         = st_q.ptr;
    assign open_o        = (st_q.state == CH_STOPPED) && !st_q.run;
    assign suspend_evt_o = st_q.evt;

    // R12
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == CH_RUNNING && !fetch_ack_i) |=> $stable(st_q.ptr));

    // R6
    susp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == CH_RUNNING && !(fetch_ack_i && !desc_owned_i) && !uf_eff)
        |=> st_q.state != CH_SUSPENDED);

    // R10
    evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.evt |-> (st_q.state == CH_SUSPENDED && $past(st_q.state) != CH_SUSPENDED));

    // R9
    stop_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == CH_SUSPENDED && !st_q.run) |=> st_q.state == CH_STOPPED);

    // R4
    resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == CH_STOPPED && st_q.run && !dirty_i) |=> $stable(st_q.ptr));

    // R3
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == CH_STOPPED && st_q.run && dirty_i) |=> st_q.ptr == $past(base_i));

    // R7
    wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == CH_SUSPENDED && st_q.run && poll_pend_i)
        |=> (st_q.state == CH_RUNNING && $stable(st_q.ptr)));
endmodule

// File: rtl/dma_desc_ptr_ctrl.sv
module dma_desc_ptr_ctrl
    import dpc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int OPM_W      = 32,
    parameter int BUS_W      = 64,
    parameter int DESC_BYTES = 16,
    parameter bit IS_TX      = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              opmode_wr,
    input  logic [OPM_W-1:0]  opmode_wdata,
    input  logic              base_wr,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              poll_wr,
    input  logic              tx_underflow,
    input  logic              fetch_ack,
    input  logic              desc_owned,
    input  logic              desc_last,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [ADDR_W-1:0] base_rd,
    output logic [1:0]        state,
    output logic              suspend_evt,
    output logic              poll_pend
);
    localparam int ALIGN_LSB = $clog2(BUS_W / 8);
    localparam int START_BIT = IS_TX ? 13 : 1;

    logic      take, open, fetch_start, dirty;
    ch_state_e st;

    dpc_base_reg #(
        .ADDR_W   (ADDR_W),
        .ALIGN_LSB(ALIGN_LSB)
    ) base_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (base_wr),
        .wdata_i(base_wdata),
        .open_i (open),
        .take_i (take),
        .base_o (base_rd),
        .dirty_o(dirty)
    );

    dpc_poll_flag poll_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .poll_wr_i    (poll_wr),
        .fetch_start_i(fetch_start),
        .pend_o       (poll_pend)
    );

    dpc_chan_fsm #(
        .ADDR_W    (ADDR_W),
        .DESC_BYTES(DESC_BYTES),
        .IS_TX     (IS_TX)
    ) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .opmode_wr_i  (opmode_wr),
        .start_bit_i  (opmode_wdata[START_BIT]),
        .base_i       (base_rd),
        .dirty_i      (dirty),
        .poll_pend_i  (poll_pend),
        .underflow_i  (tx_underflow),
        .fetch_ack_i  (fetch_ack),
        .desc_owned_i (desc_owned),
        .desc_last_i  (desc_last),
        .state_o      (st),
        .ptr_o        (fetch_addr),
        .take_o       (take),
        .open_o       (open),
        .fetch_start_o(fetch_start),
        .suspend_evt_o(suspend_evt)
    );

    assign state     = st;
    assign fetch_req = (st == CH_RUNNING);

    // R12
    req_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> state == 2'd1);
endmodule

// File: tb/dma_desc_ptr_ctrl_tb_top.sv
module dma_desc_ptr_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic opm_wr = 0, base_wr = 0, poll_wr = 0, uf = 0, ack = 0, owned = 0, last = 0;
    logic [31:0] opm_d = '0;
    logic [AW-1:0] base_d = '0;

    logic          t_req, r_req, t_evt, r_evt, t_pp, r_pp;
    logic [AW-1:0] t_addr, r_addr, t_base, r_base;
    logic [1:0]    t_st, r_st;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_desc_ptr_ctrl #(.BUS_W(64), .DESC_BYTES(16), .IS_TX(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .opmode_wr(opm_wr), .opmode_wdata(opm_d),
        .base_wr(base_wr), .base_wdata(base_d), .poll_wr(poll_wr),
        .tx_underflow(uf), .fetch_ack(ack), .desc_owned(owned), .desc_last(last),
        .fetch_req(t_req), .fetch_addr(t_addr), .base_rd(t_base), .state(t_st),
        .suspend_evt(t_evt), .poll_pend(t_pp));

    dma_desc_ptr_ctrl #(.BUS_W(128), .DESC_BYTES(16), .IS_TX(1'b0)) rx_i (
        .clk(clk), .rst_n(rst_n), .opmode_wr(opm_wr), .opmode_wdata(opm_d),
        .base_wr(base_wr), .base_wdata(base_d), .poll_wr(poll_wr),
        .tx_underflow(uf), .fetch_ack(ack), .desc_owned(owned), .desc_last(last),
        .fetch_req(r_req), .fetch_addr(r_addr), .base_rd(r_base), .state(r_st),
        .suspend_evt(r_evt), .poll_pend(r_pp));

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_opm(logic [31:0] d);
        opm_d = d; opm_wr = 1; step(); opm_wr = 0;
    endtask

    task automatic wr_base(logic [AW-1:0] d);
        base_d = d; base_wr = 1; step(); base_wr = 0;
    endtask

    task automatic pulse_ack(logic o, logic l);
        ack = 1; owned = o; last = l; step(); ack = 0; owned = 0; last = 0;
    endtask

    initial begin
        logic [AW-1:0] exp_a;
        logic [AW-1:0] hold_a;
        step(); step();
        rst_n = 1'b1;
        step();
        // R11 reset state
        chk("R11 tx state", t_st, 0);
        chk("R11 tx req", t_req, 0);
        chk("R11 tx addr", t_addr, 0);
        chk("R11 tx base", t_base, 0);
        chk("R11 tx poll", t_pp, 0);
        chk("R11 rx state", r_st, 0);

        // R2 alignment sweep on two bus widths
        for (int i = 0; i < 16; i++) begin
            wr_base(32'h1000 + i);
            chk("R2 tx align", t_base, (32'h1000 + i) & ~32'h7);
            chk("R2 rx align", r_base, (32'h1000 + i) & ~32'hF);
        end

        // R3 start with new base; R8 bit 13 starts only tx
        wr_base(32'h2000);
        wr_opm(32'h1 << 13);
        step();
        chk("R3 tx state", t_st, 1);
        chk("R12 tx req", t_req, 1);
        chk("R3 tx addr", t_addr, 32'h2000);
        chk("R8 rx not started", r_st, 0);

        // R1 base write ignored while running
        wr_base(32'h5000);
        chk("R1 tx base locked", t_base, 32'h2000);
        chk("R1 rx base open", r_base, 32'h5000);

        // R12 address stable with no ack
        step(); step(); step();
        chk("R12 addr hold", t_addr, 32'h2000);

        // R5 ring walk with wrap
        exp_a = 32'h2000;
        for (int k = 0; k < 8; k++) begin
            pulse_ack(1'b1, k == 3);
            exp_a = (k == 3) ? 32'h2000 : exp_a + 32'd16;
            chk("R5 ptr", t_addr, exp_a);
            chk("R5 running", t_st, 1);
        end

        // R6 unowned -> suspend, R10 pulse
        pulse_ack(1'b0, 1'b0);
        chk("R6 susp", t_st, 2);
        chk("R12 no req", t_req, 0);
        chk("R10 evt", t_evt, 1);
        step();
        chk("R10 evt one cycle", t_evt, 0);
        chk("R6 stays", t_st, 2);

        // R7 poll demand wake
        poll_wr = 1; step(); poll_wr = 0;
        chk("R7 pend set", t_pp, 1);
        chk("R7 still susp", t_st, 2);
        step();
        chk("R7 running", t_st, 1);
        chk("R7 same addr", t_addr, exp_a);
        chk("R7 pend clear", t_pp, 0);

        // R9 stop while running waits for ack
        hold_a = t_addr;
        wr_opm(32'h0);
        step(); step();
        chk("R9 waits for ack", t_st, 1);
        chk("R9 req held", t_req, 1);
        pulse_ack(1'b1, 1'b0);
        chk("R9 stopped", t_st, 0);
        chk("R9 ptr kept", t_addr, hold_a);

        // R4 resume without base write
        wr_opm(32'h1 << 13);
        step();
        chk("R4 resume state", t_st, 1);
        chk("R4 resume addr", t_addr, hold_a);

        // R6 underflow on tx
        uf = 1; step(); uf = 0;
        chk("R6 uf susp", t_st, 2);
        chk("R10 uf evt", t_evt, 1);

        // R9 stop from suspend
        wr_opm(32'h0);
        step();
        chk("R9 susp stop", t_st, 0);

        // R3 restart on rewritten base
        wr_base(32'h3000);
        chk("R1 stopped write", t_base, 32'h3000);
        wr_opm(32'h1 << 13);
        step();
        chk("R3 new base addr", t_addr, 32'h3000);
        wr_opm(32'h0);
        pulse_ack(1'b1, 1'b0);
        chk("R9 tx stopped", t_st, 0);

        // R8 rx started by bit 1, R6 rx ignores underflow
        wr_opm(32'h2);
        step();
        chk("R8 rx running", r_st, 1);
        chk("R8 tx ignores bit1", t_st, 0);
        chk("R3 rx first addr", r_addr, 32'h3000);
        uf = 1; step(); uf = 0;
        chk("R6 rx ignores uf", r_st, 1);
        pulse_ack(1'b0, 1'b0);
        chk("R6 rx susp", r_st, 2);
        chk("R10 rx evt", r_evt, 1);
        chk("R9 tx idle", t_st, 0);

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule